// File: doc/BRIEF.md
# Single-Wire Pulse-Count Setting Decoder

This block turns a single enable/set line into a 4-bit level code. The line is sampled in the system clock domain, and the block counts its rising edges. The count chooses one of sixteen reference levels. When the line then stays high long enough, the count becomes the new setting.

The same line also works as an enable. The first rising edge turns the block on. If the line stays low past an off timeout, the block turns off and the setting goes back to its lowest value.

A mode-select input gates the counting. Edges are counted only while it is low. While it is high, the line acts as a plain enable and leaves the setting alone.

The block drives three values downstream: the latched code, a millivolt value derived from that code, and a one-cycle strobe that marks each change of the code. Both timeouts are parameters given in system clock cycles. The system clock must run at least eight times faster than the fastest edge rate on the line.

Top module: `swire_level_decoder`

## Requirements
- R1: After reset, enable_o is 0, code_o is 0, ref_mv_o is 600 and update_o is 0.
- R2: N rising edges on wire_in (1 to 16), with mode_sel low, followed by the line held high for at least LATCH_CYC cycles, set code_o to N-1.
- R3: ref_mv_o always equals 600 + 40 * code_o (600 mV for code 0, 1200 mV for code 15).
- R4: More than 16 edges before a latch saturate the count, so code_o becomes 15.
- R5: While the line has been high for fewer than LATCH_CYC cycles after the last edge, code_o keeps its previous value.
- R6: A low phase of OFF_CYC cycles or more drives enable_o to 0 and code_o to 0.
- R7: A low phase shorter than OFF_CYC keeps enable_o at 1 and keeps the edges already counted, so counting resumes from the running total.
- R8: The edge count clears when it is latched, so the next pulse train counts from zero.
- R9: Edges that arrive while mode_sel is high are not counted and leave code_o unchanged.
- R10: update_o is high for exactly one cycle in the cycle that code_o takes a new value, and is low otherwise.
- R11: enable_o goes high on the third clock edge after wire_in first rises, which is the two-flop synchronizer delay plus one register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wire_in | input | 1 | Asynchronous single-wire enable/set line |
| mode_sel | input | 1 | Low enables pulse programming; high uses the line as a plain enable |
| enable_o | output | 1 | Block enabled |
| code_o | output | 4 | Latched setting code, 0 to 15 |
| ref_mv_o | output | 11 | Reference level in millivolts for the latched code |
| update_o | output | 1 | One-cycle strobe when code_o changes |

## Verification
The hardest case to reach from the ports is a train that is interrupted. A long low phase falls between edges. It is still shorter than the off timeout, so it must neither disable the block nor drop the edges already counted.

The bench builds this case directly. It sends two edges, holds the line low for 100 cycles against an off timeout of 256, and then sends four more edges. The latched code must reflect all six edges.

A second case is a train held high for only part of the latch window. Sampling code_o inside that window shows that nothing is committed early.

// File: rtl/swd_pkg.sv
package swd_pkg;
    // width of the latched level code (sixteen levels)
    localparam int CODE_W = 4;
    typedef logic [CODE_W-1:0] swd_code_t;
endpackage

// File: rtl/swd_sync.sv
module swd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level_o,
    output logic rise_o
);
    // STAGES synchronizer flops plus one history flop for edge detection
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign level_o = sh_q[STAGES-1];
    assign rise_o  = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/swd_pulse_ctrl.sv
module swd_pulse_ctrl
    import swd_pkg::*;
#(
    parameter int LATCH_CYC  = 64,
    parameter int OFF_CYC    = 256,
    parameter int NUM_LEVELS = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      level,
    input  logic      rise,
    input  logic      mode_sel,
    output logic      en_o,
    output swd_code_t code_o,
    output logic      upd_o
);
    localparam int CNT_W = $clog2(NUM_LEVELS + 1);
    localparam int LAT_W = $clog2(LATCH_CYC + 1);
    localparam int OFF_W = $clog2(OFF_CYC + 1);

    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] cnt;
        logic [LAT_W-1:0] hi;
        logic [OFF_W-1:0] lo;
        swd_code_t        code;
        logic             upd;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  latch_hit, off_hit;

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;

        // the line has been low for OFF_CYC consecutive cycles
        off_hit   = !level && (st_q.lo == OFF_W'(OFF_CYC - 1));
        // the line has been high for LATCH_CYC cycles with edges pending
        latch_hit = level && !rise && (st_q.cnt != '0)
                    && (st_q.hi >= LAT_W'(LATCH_CYC - 1));

        // low-phase timer, saturating
        if (level)                          st_d.lo = '0;
        else if (st_q.lo != OFF_W'(OFF_CYC)) st_d.lo = st_q.lo + 1'b1;

        // high-phase timer, saturating
        if (!level)                              st_d.hi = '0;
        else if (st_q.hi != LAT_W'(LATCH_CYC))   st_d.hi = st_q.hi + 1'b1;

        if (rise) begin
            st_d.en = 1'b1;
            if (!mode_sel && st_q.cnt != CNT_W'(NUM_LEVELS))
                st_d.cnt = st_q.cnt + 1'b1;
        end

        if (mode_sel) st_d.cnt = '0;

        if (latch_hit) begin
            st_d.code = CODE_W'(st_q.cnt - 1'b1);
            st_d.cnt  = '0;
        end

        if (off_hit) begin
            st_d.en   = 1'b0;
            st_d.code = '0;
            st_d.cnt  = '0;
        end

        st_d.upd = (st_d.code != st_q.code);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o   = st_q.en;
    assign code_o = st_q.code;
    assign upd_o  = st_q.upd;
endmodule

// File: rtl/swd_level_map.sv
module swd_level_map
    import swd_pkg::*;
#(
    parameter int BASE_MV = 600,
    parameter int STEP_MV = 40,
    parameter int REF_W   = 11
) (
    input  swd_code_t        code,
    output logic [REF_W-1:0] ref_mv
);
    always_comb begin
        ref_mv = REF_W'(BASE_MV) + REF_W'(STEP_MV) * REF_W'(code);
    end
endmodule

// File: rtl/swire_level_decoder.sv
module swire_level_decoder #(
    parameter int LATCH_CYC   = 64,
    parameter int OFF_CYC     = 256,
    parameter int SYNC_STAGES = 2,
    parameter int BASE_MV     = 600,
    parameter int STEP_MV     = 40,
    parameter int NUM_LEVELS  = 16,
    parameter int REF_W       = $clog2(BASE_MV + (NUM_LEVELS - 1) * STEP_MV + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wire_in,
    input  logic             mode_sel,
    output logic             enable_o,
    output logic [3:0]       code_o,
    output logic [REF_W-1:0] ref_mv_o,
    output logic             update_o
);
    logic level, rise;

    swd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (wire_in),
        .level_o (level),
        .rise_o  (rise)
    );

    swd_pulse_ctrl #(
        .LATCH_CYC  (LATCH_CYC),
        .OFF_CYC    (OFF_CYC),
        .NUM_LEVELS (NUM_LEVELS)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (level),
        .rise     (rise),
        .mode_sel (mode_sel),
        .en_o     (enable_o),
        .code_o   (code_o),
        .upd_o    (update_o)
    );

    swd_level_map #(
        .BASE_MV (BASE_MV),
        .STEP_MV (STEP_MV),
        .REF_W   (REF_W)
    ) u_map (
        .code   (code_o),
        .ref_mv (ref_mv_o)
    );
endmodule

// File: rtl/swd_checker.sv
module swd_checker #(
    parameter int BASE_MV    = 600,
    parameter int STEP_MV    = 40,
    parameter int NUM_LEVELS = 16,
    parameter int REF_W      = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wire_in,
    input logic             enable_o,
    input logic [3:0]       code_o,
    input logic [REF_W-1:0] ref_mv_o,
    input logic             update_o
);
    localparam int MAX_MV = BASE_MV + (NUM_LEVELS - 1) * STEP_MV;

    // a change of the code is always flagged by the strobe
    assert_code_change_strobed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o != $past(code_o)) |-> update_o);

    // the strobe lasts a single cycle
    assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |=> !update_o);

    // the reference stays inside the sixteen-level range
    assert_ref_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_mv_o >= REF_W'(BASE_MV)) && (ref_mv_o <= REF_W'(MAX_MV)));

    // while disabled the setting sits at its default
    assert_disabled_default_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_o |-> (code_o == 4'd0));

    // turning on needs the line high through the synchronizer
    assert_enable_from_line_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enable_o) |-> $past(wire_in, 2));
endmodule

bind swire_level_decoder swd_checker #(
    .BASE_MV    (BASE_MV),
    .STEP_MV    (STEP_MV),
    .NUM_LEVELS (NUM_LEVELS),
    .REF_W      (REF_W)
) u_swd_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .wire_in  (wire_in),
    .enable_o (enable_o),
    .code_o   (code_o),
    .ref_mv_o (ref_mv_o),
    .update_o (update_o)
);

// File: tb/test_swire_level_decoder.sv
module test_swire_level_decoder;
    localparam int LAT  = 64;
    localparam int OFF  = 256;
    localparam int PH   = 8;
    localparam int HOLD = LAT + 40;
    localparam int NV   = 6;
    localparam int VEC_PULSES [NV] = '{1, 3, 16, 20, 7, 2};
    localparam int VEC_CODE   [NV] = '{0, 2, 15, 15, 6, 1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wire_in = 1'b0;
    logic        mode_sel = 1'b0;
    logic        enable_o;
    logic [3:0]  code_o;
    logic [10:0] ref_mv_o;
    logic        update_o;

    int n_chk = 0;
    int n_bad = 0;
    int upd_seen = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    swire_level_decoder #(.LATCH_CYC(LAT), .OFF_CYC(OFF)) i_swire_level_decoder (
        .clk      (clk),
        .rst_n    (rst_n),
        .wire_in  (wire_in),
        .mode_sel (mode_sel),
        .enable_o (enable_o),
        .code_o   (code_o),
        .ref_mv_o (ref_mv_o),
        .update_o (update_o)
    );

    always @(negedge clk) if (update_o) upd_seen++;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            wire_in = 1'b0; wait_cyc(PH);
            wire_in = 1'b1; wait_cyc(PH);
        end
    endtask

    initial begin
        int prev;
        wait_cyc(3);
        // R1: reset state
        chk("R1 enable", int'(enable_o), 0);
        chk("R1 code", int'(code_o), 0);
        chk("R1 ref", int'(ref_mv_o), 600);
        chk("R1 update", int'(update_o), 0);
        rst_n = 1'b1;
        wait_cyc(2);

        // R2 R3 R4 R8 R10: vector walk
        prev = 0;
        for (int v = 0; v < NV; v++) begin
            upd_seen = 0;
            pulses(VEC_PULSES[v]);
            wait_cyc(HOLD);
            chk("R2/R4/R8 code", int'(code_o), VEC_CODE[v]);
            chk("R3 ref", int'(ref_mv_o), 600 + 40 * VEC_CODE[v]);
            chk("R10 strobes", upd_seen, (VEC_CODE[v] != prev) ? 1 : 0);
            prev = VEC_CODE[v];
        end

        // R5: no commit inside the latch window
        pulses(4);
        wait_cyc(LAT / 3);
        chk("R5 early code", int'(code_o), 1);
        wait_cyc(HOLD);
        chk("R2 late code", int'(code_o), 3);

        // R7: long but sub-timeout low keeps enable and count
        pulses(2);
        wire_in = 1'b0; wait_cyc(100);
        chk("R7 enable held", int'(enable_o), 1);
        wire_in = 1'b1; wait_cyc(PH);
        pulses(3);
        wait_cyc(HOLD);
        chk("R7 code", int'(code_o), 5);

        // R9: edges ignored with mode_sel high
        mode_sel = 1'b1;
        upd_seen = 0;
        pulses(5);
        wait_cyc(HOLD);
        chk("R9 code", int'(code_o), 5);
        chk("R9 strobes", upd_seen, 0);
        mode_sel = 1'b0;

        // R6: off timeout
        upd_seen = 0;
        wire_in = 1'b0; wait_cyc(OFF + 20);
        chk("R6 enable", int'(enable_o), 0);
        chk("R6 code", int'(code_o), 0);
        chk("R6 ref", int'(ref_mv_o), 600);
        chk("R10 off strobe", upd_seen, 1);

        // R11: enable latency from first rise
        wire_in = 1'b1;
        wait_cyc(2);
        chk("R11 enable early", int'(enable_o), 0);
        wait_cyc(1);
        chk("R11 enable on", int'(enable_o), 1);
        wait_cyc(HOLD);
        chk("R2 single edge code", int'(code_o), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule